// File: doc/BRIEF.md
# Prescaled Compare-Match Interval Timer Bank

This block holds a bank of independent 16-bit interval timers behind one small register port. Each timer has three registers. The count register can only be read. The compare register can be read and written. The control register holds two run enables and a three-bit prescaler select. While a timer runs, its counter steps once per prescaler tick. When the counter equals the compare value at a tick, the timer returns to zero and pulses its own interrupt request for one clock cycle. The result is a periodic interrupt whose period is set by the compare value and the prescaler.

Software sets a period by choosing a prescaler select and a compare value, and then turns on both enables. Interrupt masking and routing are done by logic outside the bank, so starting a timer never enables its interrupt. The prescaler select holds the log2 of the divider minus two. A select of 0 divides the clock by 4 and a select of 7 divides it by 512.

Top module: `ivtimer_bank`

## Requirements
- R1: During and after a synchronous reset, every count, compare and control register reads zero and no interrupt request is asserted.
- R2: Unit u occupies bus addresses u*0x10 to u*0x10+0xF. Within that range, offset 0x0 is the count, 0x4 is the compare and 0x8 is the control. Control bit 0 is the clock enable, bit 1 is the count enable and bits [6:4] are the prescaler select. Control bits 2, 3 and 7 read as zero. Read data appears on the cycle after the read strobe. Unmapped offsets, and addresses above the last unit, read zero and ignore writes.
- R3: A write to a count register has no effect on that count.
- R4: The counter only moves while both enables are 1. With only the clock enable set, the count holds its value. With the clock enable clear, the count and the prescaler are held at zero.
- R5: One prescaler tick occurs every 2^(select+2) clock cycles, counted from the write that sets the clock enable. After k ticks the count reads k.
- R6: When the count equals the compare value at a tick, the count returns to zero and an interrupt pulse follows. The first pulse comes (compare+1)*2^(select+2) cycles after the enabling write, and later pulses repeat at that same interval.
- R7: Each interrupt request pulse lasts exactly one clock cycle.
- R8: Units run independently. Traffic to one unit does not change the count, period or pulses of another unit.
- R9: A compare value of zero gives one pulse per prescaler period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | CW (16) | Write data; control uses bits [7:0] |
| bus_rdata | output | CW (16) | Registered read data |
| irq_req | output | NUNITS (4) | Per-unit compare-match pulse |

## Verification
The bench builds the bank with its default parameters: four units, 16-bit counters and an 8-bit address. With these values every unit, and every address above the last unit, can be reached from the bench. All eight prescaler selects are swept, each with a small compare value, and compare values 0 to 5 are swept under the two fastest prescalers. The longest period is then about 1.5k cycles, so the exact arrival cycle of every first pulse and the spacing of later pulses can be computed arithmetically. Exact count readbacks under several prescalers cover single ticks. A concurrent run of three units with different periods, beside an idle fourth unit, covers independence.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  localparam int STRIDE_LG2 = 4;
  localparam int SEL_W      = 3;
  localparam int PSC_OFFSET = 2;
  localparam int PSC_W      = (1 << SEL_W) - 1 + PSC_OFFSET;

  localparam logic [STRIDE_LG2-1:0] OFS_COUNT = 4'h0;
  localparam logic [STRIDE_LG2-1:0] OFS_CMP   = 4'h4;
  localparam logic [STRIDE_LG2-1:0] OFS_CTRL  = 4'h8;

  typedef enum logic [1:0] {
    REG_NONE  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CMP   = 2'd2,
    REG_CTRL  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             cnt_en;
    logic             clk_en;
  } ctrl_t;

  function automatic logic [7:0] ctrl_to_byte(input ctrl_t c);
    return {1'b0, c.sel, 2'b00, c.cnt_en, c.clk_en};
  endfunction

  function automatic ctrl_t byte_to_ctrl(input logic [7:0] b);
    ctrl_t c;
    c.sel    = b[6:4];
    c.cnt_en = b[1];
    c.clk_en = b[0];
    return c;
  endfunction

endpackage

// File: rtl/ivt_regdec.sv
module ivt_regdec
  import ivt_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NUNITS = 4,
  localparam int UIW   = $clog2(NUNITS)
) (
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  output logic [NUNITS-1:0] wr_cmp,
  output logic [NUNITS-1:0] wr_ctrl,
  output logic              hit,
  output logic [UIW-1:0]    unit_idx,
  output reg_kind_e         kind
);

  localparam int TOPB = STRIDE_LG2 + UIW;

  logic upper_ok;

  generate
    if (AW > TOPB) begin : g_upper
      assign upper_ok = (addr[AW-1:TOPB] == '0);
    end else begin : g_noupper
      assign upper_ok = 1'b1;
    end
  endgenerate

  assign unit_idx = addr[STRIDE_LG2 +: UIW];

  always_comb begin
    case (addr[STRIDE_LG2-1:0])
      OFS_COUNT: kind = REG_COUNT;
      OFS_CMP:   kind = REG_CMP;
      OFS_CTRL:  kind = REG_CTRL;
      default:   kind = REG_NONE;
    endcase
  end

  assign hit = upper_ok && (int'(unit_idx) < NUNITS) && (kind != REG_NONE);

  // Count writes deliberately produce no enable.
  always_comb begin
    wr_cmp  = '0;
    wr_ctrl = '0;
    if (wr && hit) begin
      case (kind)
        REG_CMP:  wr_cmp[unit_idx]  = 1'b1;
        REG_CTRL: wr_ctrl[unit_idx] = 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
  import ivt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;

  // Low (sel + offset) bits set: tick once they are all ones.
  assign mask = ~({PSC_W{1'b1}} << (int'(sel) + PSC_OFFSET));
  assign tick = run && ((psc_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) psc_q <= '0;
    else             psc_q <= psc_q + 1'b1;
  end

endmodule

// File: rtl/ivt_unit.sv
module ivt_unit
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cmp,
  input  logic          wr_ctrl,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cmp,
  output ctrl_t         ctrl,
  output logic          irq
);

  logic tick;
  logic step;
  logic match;

  ivt_prescaler u_psc (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl.clk_en),
    .sel  (ctrl.sel),
    .tick (tick)
  );

  assign step  = tick && ctrl.cnt_en;
  assign match = (cnt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      cmp  <= '0;
    end else begin
      if (wr_ctrl) ctrl <= byte_to_ctrl(wdata[7:0]);
      if (wr_cmp)  cmp  <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ctrl.clk_en) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= match ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= step && match;
  end

endmodule

// File: rtl/ivtimer_bank.sv
module ivtimer_bank
  import ivt_pkg::*;
#(
  parameter int AW     = 8,
  parameter int CW     = 16,
  parameter int NUNITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [CW-1:0]     bus_wdata,
  output logic [CW-1:0]     bus_rdata,
  output logic [NUNITS-1:0] irq_req
);

  localparam int UIW = $clog2(NUNITS);

  logic [NUNITS-1:0]         dec_wr_cmp;
  logic [NUNITS-1:0]         dec_wr_ctrl;
  logic                      dec_hit;
  logic [UIW-1:0]            dec_idx;
  reg_kind_e                 dec_kind;

  logic [NUNITS-1:0][CW-1:0] unit_cnt;
  logic [NUNITS-1:0][CW-1:0] unit_cmp;
  ctrl_t                     unit_ctrl [NUNITS];
  logic [NUNITS-1:0]         unit_clk_en;
  logic [NUNITS-1:0]         unit_cnt_en;
  logic [CW-1:0]             rd_mux;

  ivt_regdec #(.AW(AW), .NUNITS(NUNITS)) u_dec (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wr_cmp   (dec_wr_cmp),
    .wr_ctrl  (dec_wr_ctrl),
    .hit      (dec_hit),
    .unit_idx (dec_idx),
    .kind     (dec_kind)
  );

  generate
    for (genvar u = 0; u < NUNITS; u++) begin : g_unit
      ivt_unit #(.CW(CW)) u_unit (
        .clk     (clk),
        .rst     (rst),
        .wr_cmp  (dec_wr_cmp[u]),
        .wr_ctrl (dec_wr_ctrl[u]),
        .wdata   (bus_wdata),
        .cnt     (unit_cnt[u]),
        .cmp     (unit_cmp[u]),
        .ctrl    (unit_ctrl[u]),
        .irq     (irq_req[u])
      );
      assign unit_clk_en[u] = unit_ctrl[u].clk_en;
      assign unit_cnt_en[u] = unit_ctrl[u].cnt_en;
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (dec_hit) begin
      case (dec_kind)
        REG_COUNT: rd_mux = unit_cnt[dec_idx];
        REG_CMP:   rd_mux = unit_cmp[dec_idx];
        REG_CTRL:  rd_mux = CW'(ctrl_to_byte(unit_ctrl[dec_idx]));
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
  parameter int NUNITS = 4,
  parameter int CW     = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUNITS-1:0]         irq_req,
  input logic [NUNITS-1:0][CW-1:0] cnt_all,
  input logic [NUNITS-1:0][CW-1:0] cmp_all,
  input logic [NUNITS-1:0]         clk_en_all,
  input logic [NUNITS-1:0]         cnt_en_all
);

  // R1: reset drops every request on the following cycle
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (irq_req == '0));

  generate
    for (genvar u = 0; u < NUNITS; u++) begin : g_chk
      // R7: a request never lasts two cycles
      a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_req[u] |=> !irq_req[u]);

      // R4: clock enable low forces the count to zero
      a_r4_off_clears: assert property (@(posedge clk) disable iff (rst)
        !clk_en_all[u] |=> (cnt_all[u] == '0));

      // R4: count enable low freezes the count
      a_r4_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (clk_en_all[u] && !cnt_en_all[u]) |=> $stable(cnt_all[u]));

      // R6: a request follows a match and the count has restarted
      a_r6_pulse_on_match: assert property (@(posedge clk) disable iff (rst)
        irq_req[u] |-> ((cnt_all[u] == '0) && $past(cnt_all[u] == cmp_all[u])));

      // R5: the count only steps by one or returns to zero
      a_r5_unit_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_all[u] != $past(cnt_all[u])) |->
          ((cnt_all[u] == $past(cnt_all[u]) + 1'b1) || (cnt_all[u] == '0)));
    end
  endgenerate

endmodule

bind ivtimer_bank ivt_checker #(.NUNITS(NUNITS), .CW(CW)) u_ivt_checker (
  .clk        (clk),
  .rst        (rst),
  .irq_req    (irq_req),
  .cnt_all    (unit_cnt),
  .cmp_all    (unit_cmp),
  .clk_en_all (unit_clk_en),
  .cnt_en_all (unit_cnt_en)
);

// File: tb/tb_ivtimer_bank.sv
`timescale 1ns/1ps
module tb_ivtimer_bank;

  localparam int AW = 8;
  localparam int CW = 16;
  localparam int NU = 4;
  localparam int TCK = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic [NU-1:0] irq_req;

  int n_chk = 0;
  int n_fail = 0;

  int  pulse_cnt [NU];
  time ptime [NU][4];
  bit  wide_seen [NU];
  logic [NU-1:0] irq_prev = '0;

  always #(TCK/2) clk = ~clk;

  ivtimer_bank #(.AW(AW), .CW(CW), .NUNITS(NU)) dut (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req)
  );

  initial begin
    for (int u = 0; u < NU; u++) begin
      pulse_cnt[u] = 0;
      wide_seen[u] = 1'b0;
    end
  end

  always @(negedge clk) begin
    for (int u = 0; u < NU; u++) begin
      if (irq_req[u] === 1'b1) begin
        ptime[u][pulse_cnt[u] % 4] = $time;
        pulse_cnt[u] = pulse_cnt[u] + 1;
        if (irq_prev[u] === 1'b1) wide_seen[u] = 1'b1;
      end
    end
    irq_prev = irq_req;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data, output time t_w);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = CW'(data);
    t_w = $time;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output int data, output time t_r);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(addr);
    t_r = $time;
    @(negedge clk);
    data = int'(bus_rdata);
    bus_rd = 1'b0;
  endtask

  function automatic int a_cnt(input int u);  return u * 16 + 0; endfunction
  function automatic int a_cmp(input int u);  return u * 16 + 4; endfunction
  function automatic int a_ctl(input int u);  return u * 16 + 8; endfunction

  task automatic run_period(input int u, input int cmpv, input int sel, input string req);
    time t_w, t_d;
    int base, div, per;
    div = 1 << (sel + 2);
    per = (cmpv + 1) * div * TCK;
    wr(a_cmp(u), cmpv, t_d);
    base = pulse_cnt[u];
    wr(a_ctl(u), 3 | (sel << 4), t_w);
    while (pulse_cnt[u] < base + 3) @(negedge clk);
    check(ptime[u][base % 4] - t_w == time'(TCK + per), req, "first pulse delay",
          longint'(ptime[u][base % 4] - t_w), longint'(TCK + per));
    check(ptime[u][(base + 1) % 4] - ptime[u][base % 4] == time'(per), req, "period",
          longint'(ptime[u][(base + 1) % 4] - ptime[u][base % 4]), longint'(per));
    check(ptime[u][(base + 2) % 4] - ptime[u][(base + 1) % 4] == time'(per), req, "period 2",
          longint'(ptime[u][(base + 2) % 4] - ptime[u][(base + 1) % 4]), longint'(per));
    check(!wide_seen[u], "R7", "pulse wider than one cycle", longint'(wide_seen[u]), 0);
    wr(a_ctl(u), 0, t_d);
  endtask

  initial begin : watchdog
    repeat (150000) @(negedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int d, p0, m, expv;
    time tw, tr, td;
    int u0_pulses;

    repeat (4) @(negedge clk);
    check(irq_req == '0, "R1", "irq during reset", longint'(irq_req), 0);
    rst = 1'b0;

    // R1: all registers zero after reset
    for (int u = 0; u < NU; u++) begin
      rd(a_cnt(u), d, tr); check(d == 0, "R1", "count after reset", d, 0);
      rd(a_cmp(u), d, tr); check(d == 0, "R1", "compare after reset", d, 0);
      rd(a_ctl(u), d, tr); check(d == 0, "R1", "control after reset", d, 0);
    end

    // R2: map, stride, control field layout
    for (int u = 0; u < NU; u++) wr(a_cmp(u), 16'h1100 + u * 16'h0111, td);
    for (int u = 0; u < NU; u++) begin
      rd(a_cmp(u), d, tr);
      check(d == 16'h1100 + u * 16'h0111, "R2", "compare readback", d, 16'h1100 + u * 16'h0111);
    end
    wr(a_ctl(3), 16'h00FC, td);
    rd(a_ctl(3), d, tr); check(d == 16'h0070, "R2", "control masked readback", d, 16'h0070);
    wr(a_ctl(3), 0, td);
    rd(3 * 16 + 12, d, tr); check(d == 0, "R2", "unmapped offset", d, 0);
    wr(8'h44, 16'hBEEF, td);
    wr(8'hC4, 16'hBEEF, td);
    rd(8'h44, d, tr); check(d == 0, "R2", "beyond last unit read", d, 0);
    for (int u = 0; u < NU; u++) begin
      rd(a_cmp(u), d, tr);
      check(d == 16'h1100 + u * 16'h0111, "R2", "compare after stray write", d, 16'h1100 + u * 16'h0111);
    end

    // R3: count write ignored while idle
    wr(a_cnt(1), 16'h1234, td);
    rd(a_cnt(1), d, tr); check(d == 0, "R3", "count write idle", d, 0);

    // R5: exact count readback under several prescalers, with a count write between reads
    wr(a_cmp(0), 16'hFFFF, td);
    for (int s = 0; s < 3; s++) begin
      wr(a_ctl(0), 3 | (s << 4), tw);
      repeat (37 + 11 * s) @(negedge clk);
      rd(a_cnt(0), d, tr);
      m = int'((tr - tw) / TCK);
      expv = (m - 1) / (1 << (s + 2));
      check(d == expv, "R5", "count readback", d, expv);
      wr(a_cnt(0), 16'h7777, td);
      repeat (19) @(negedge clk);
      rd(a_cnt(0), d, tr);
      m = int'((tr - tw) / TCK);
      expv = (m - 1) / (1 << (s + 2));
      check(d == expv, "R3", "count after count write", d, expv);
      wr(a_ctl(0), 0, td);
      rd(a_cnt(0), d, tr); check(d == 0, "R4", "clock enable off clears", d, 0);
    end

    // R4: either enable alone never counts
    u0_pulses = pulse_cnt[0];
    wr(a_cmp(0), 0, td);
    wr(a_ctl(0), 16'h0001, td);
    repeat (60) @(negedge clk);
    rd(a_cnt(0), d, tr); check(d == 0, "R4", "clock enable only", d, 0);
    wr(a_ctl(0), 16'h0002, td);
    repeat (60) @(negedge clk);
    rd(a_cnt(0), d, tr); check(d == 0, "R4", "count enable only", d, 0);
    check(pulse_cnt[0] == u0_pulses, "R4", "no pulses with one enable", pulse_cnt[0], u0_pulses);
    wr(a_cmp(0), 16'hFFFF, td);
    wr(a_ctl(0), 16'h0003, td);
    repeat (50) @(negedge clk);
    wr(a_ctl(0), 16'h0001, td);
    rd(a_cnt(0), p0, tr);
    repeat (40) @(negedge clk);
    rd(a_cnt(0), d, tr);
    check(p0 != 0, "R4", "count advanced before hold", p0, 1);
    check(d == p0, "R4", "count held with count enable low", d, p0);
    wr(a_ctl(0), 16'h0002, td);
    rd(a_cnt(0), d, tr); check(d == 0, "R4", "clock enable cleared", d, 0);
    wr(a_ctl(0), 0, td);

    // R5/R6: every prescaler select with a small compare
    for (int s = 0; s < 8; s++) run_period(2, 2, s, "R5");
    // R6/R9: compare sweep under the two fastest selects
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 6; c++) run_period(1, c, s, (c == 0) ? "R9" : "R6");

    // R8: three units at once, unit 2 idle
    begin
      time tw0, tw1, tw3;
      int b0, b1, b2, b3;
      b0 = pulse_cnt[0]; b1 = pulse_cnt[1]; b2 = pulse_cnt[2]; b3 = pulse_cnt[3];
      wr(a_cmp(0), 4, td); wr(a_cmp(1), 2, td); wr(a_cmp(3), 9, td);
      wr(a_ctl(0), 16'h0003, tw0);
      wr(a_ctl(1), 16'h0013, tw1);
      wr(a_ctl(3), 16'h0003, tw3);
      repeat (400) @(negedge clk);
      wr(a_cmp(2), 7, td);
      repeat (100) @(negedge clk);
      wr(a_ctl(0), 0, td); wr(a_ctl(1), 0, td); wr(a_ctl(3), 0, td);
      repeat (4) @(negedge clk);
      check(pulse_cnt[2] == b2, "R8", "idle unit pulses", pulse_cnt[2] - b2, 0);
      check(pulse_cnt[0] - b0 > 3, "R8", "unit0 pulses", pulse_cnt[0] - b0, 4);
      check((ptime[0][(pulse_cnt[0] - 1) % 4] - tw0 - TCK) % (20 * TCK) == 0, "R8", "unit0 phase",
            longint'((ptime[0][(pulse_cnt[0] - 1) % 4] - tw0 - TCK) % (20 * TCK)), 0);
      check((ptime[1][(pulse_cnt[1] - 1) % 4] - tw1 - TCK) % (24 * TCK) == 0, "R8", "unit1 phase",
            longint'((ptime[1][(pulse_cnt[1] - 1) % 4] - tw1 - TCK) % (24 * TCK)), 0);
      check((ptime[3][(pulse_cnt[3] - 1) % 4] - tw3 - TCK) % (40 * TCK) == 0, "R8", "unit3 phase",
            longint'((ptime[3][(pulse_cnt[3] - 1) % 4] - tw3 - TCK) % (40 * TCK)), 0);
      check(pulse_cnt[3] - b3 == (500 * TCK) / (40 * TCK) || pulse_cnt[3] - b3 == (500 * TCK) / (40 * TCK) + 1,
            "R8", "unit3 pulse count", pulse_cnt[3] - b3, 12);
      check(pulse_cnt[1] - b1 > 10, "R8", "unit1 pulse count", pulse_cnt[1] - b1, 21);
      for (int u = 0; u < NU; u++)
        check(!wide_seen[u], "R7", "concurrent pulse width", longint'(wide_seen[u]), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule